// File: doc/BRIEF.md
# ROM-Driven Four-Way Branch Sequencer

This block is a microprogrammed controller. A 4-bit state register addresses a computed ROM. The ROM supplies 14 datapath control lines and the next state. Every state has exactly four successors. The choice among them comes from two condition bits, and each of those bits is picked out of a 4-bit condition vector by a 2:1 multiplexer. The control lines belong to the current state only, so the controller behaves as a synchronous Moore machine.

A parameter picks one of two ROM layouts, and both run the same microprogram.

- **Vertical layout** (`IS_HORIZONTAL = 0`):
  - The state and the two chosen condition bits form a 6-bit address into 64 words of 18 bits.
  - The multiplexer selects are decoded from the state.
- **Horizontal layout** (`IS_HORIZONTAL = 1`):
  - There are 16 words of 32 bits, one word per state.
  - Each word carries all four candidate successors and two encoded multiplexer-select bits.
  - Each next-state bit comes from a 4:1 multiplexer over the same bit of the four candidates.

Top module: `seqBranchSequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) forces `state` to 0 at that edge, and `ctrlOut` then shows the control word of state 0.
- R2: `ctrlOut` always equals the control word of the current state `s`, which is {~s, s, s XOR 4'h5, s[3] XOR s[0], s[1]}, most significant part first.
- R3: In state `s`, the low branch bit `a` is `cond[1]` when `s[0]` is 1 and `cond[0]` otherwise. The high branch bit `b` is `cond[3]` when `s[1]` is 1 and `cond[2]` otherwise.
- R4: Out of reset, each rising edge loads `state` with (5*s + 3*k + 1) mod 16, where k = 2*b + a.
- R5: The two condition bits that the current state does not select have no effect on the next state.
- R6: The vertical and horizontal layouts produce identical `state` and `ctrlOut` traces for the same reset and condition stimulus.
- R7: `state` changes only at a rising clock edge. Changes on `cond` between edges leave `state` untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cond | input | 4 | Condition inputs feeding the branch multiplexers |
| ctrlOut | output | 14 | Datapath control lines of the current state |
| state | output | 4 | Current microprogram state |

## Verification
The state is visible as a port, so a wrong successor shows on `state` one cycle after the faulty edge. The control lines follow it in the same cycle. A wrong condition select is subtler: it only shows when the chosen bit and the bit it should have chosen differ. That is why stimulus drives the unselected inputs against the selected ones. A layout-specific fault, such as a swapped candidate field or a swapped select bit, shows as a divergence between the two layouts within one cycle of reaching an affected state.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int STATE_W = 4;
  localparam int CTRL_W  = 14;
  localparam int COND_W  = 4;
  localparam int NUM_STATES = 1 << STATE_W;
  localparam int BRANCH_W = 2;
  localparam int NUM_BRANCH = 1 << BRANCH_W;
  localparam int VERT_ADDR_W = STATE_W + BRANCH_W;

  typedef logic [STATE_W-1:0] state_t;
  typedef logic [CTRL_W-1:0]  ctrl_t;

  // Strobes handed from the ROM (control) to the state register (datapath).
  typedef struct packed {
    ctrl_t  ctrl;
    state_t nextState;
  } seqStrobe_t;

  typedef struct packed {
    logic betaSel;
    logic alphaSel;
  } condSel_t;

  typedef struct packed {
    ctrl_t  ctrl;
    state_t next;
  } vertWord_t;

  typedef struct packed {
    ctrl_t                        ctrl;
    logic [NUM_BRANCH-1:0][STATE_W-1:0] cand;
    condSel_t                     sel;
  } horzWord_t;

  // Microprogram definition shared by both layouts.
  function automatic ctrl_t progCtrl(state_t s);
    return {~s, s, s ^ 4'h5, s[3] ^ s[0], s[1]};
  endfunction

  function automatic state_t progNext(state_t s, logic [BRANCH_W-1:0] k);
    state_t t;
    t = s * 4'd5 + {2'b00, k} * 4'd3 + 4'd1;
    return t;
  endfunction

  function automatic condSel_t progSel(state_t s);
    condSel_t c;
    c.alphaSel = s[0];
    c.betaSel  = s[1];
    return c;
  endfunction

  function automatic vertWord_t vertRomWord(logic [VERT_ADDR_W-1:0] addr);
    vertWord_t w;
    w.ctrl = progCtrl(addr[VERT_ADDR_W-1:BRANCH_W]);
    w.next = progNext(addr[VERT_ADDR_W-1:BRANCH_W], addr[BRANCH_W-1:0]);
    return w;
  endfunction

  function automatic horzWord_t horzRomWord(state_t s);
    horzWord_t w;
    w.ctrl = progCtrl(s);
    for (int k = 0; k < NUM_BRANCH; k++) begin
      w.cand[k] = progNext(s, BRANCH_W'(k));
    end
    w.sel = progSel(s);
    return w;
  endfunction
endpackage

// File: rtl/seqCondMux.sv
module seqCondMux
  import seqPkg::*;
(
  input  logic [COND_W-1:0]   cond,
  input  condSel_t            sel,
  output logic [BRANCH_W-1:0] condPair
);
  logic alphaBit;
  logic betaBit;

  always_comb begin
    alphaBit = sel.alphaSel ? cond[1] : cond[0];
    betaBit  = sel.betaSel  ? cond[3] : cond[2];
    condPair = {betaBit, alphaBit};
  end
endmodule

// File: rtl/seqRom.sv
module seqRom
  import seqPkg::*;
#(
  parameter bit IS_HORIZONTAL = 1'b0
) (
  input  state_t              state,
  input  logic [BRANCH_W-1:0] condPair,
  output condSel_t            condSel,
  output seqStrobe_t          strobe
);
  generate
    if (IS_HORIZONTAL) begin : g_horz
      horzWord_t word;
      assign word    = horzRomWord(state);
      assign condSel = word.sel;
      assign strobe.ctrl = word.ctrl;
      for (genvar i = 0; i < STATE_W; i++) begin : g_bitMux
        logic [NUM_BRANCH-1:0] candBits;
        for (genvar k = 0; k < NUM_BRANCH; k++) begin : g_gather
          assign candBits[k] = word.cand[k][i];
        end
        assign strobe.nextState[i] = candBits[condPair];
      end
    end else begin : g_vert
      logic [VERT_ADDR_W-1:0] romAddr;
      vertWord_t word;
      assign condSel = progSel(state);
      assign romAddr = {state, condPair};
      assign word    = vertRomWord(romAddr);
      assign strobe.ctrl      = word.ctrl;
      assign strobe.nextState = word.next;
    end
  endgenerate
endmodule

// File: rtl/seqStateReg.sv
module seqStateReg
  import seqPkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_t nextState,
  output state_t state
);
  always_ff @(posedge clk) begin
    if (rst) state <= '0;
    else     state <= nextState;
  end
endmodule

// File: rtl/seqBranchSequencer.sv
module seqBranchSequencer
  import seqPkg::*;
#(
  parameter bit IS_HORIZONTAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic [STATE_W-1:0] state
);
  condSel_t            condSel;
  logic [BRANCH_W-1:0] condPair;
  seqStrobe_t          strobe;
  state_t              curState;

  seqCondMux u_condMux (
    .cond     (cond),
    .sel      (condSel),
    .condPair (condPair)
  );

  seqRom #(.IS_HORIZONTAL(IS_HORIZONTAL)) u_rom (
    .state    (curState),
    .condPair (condPair),
    .condSel  (condSel),
    .strobe   (strobe)
  );

  seqStateReg u_stateReg (
    .clk       (clk),
    .rst       (rst),
    .nextState (strobe.nextState),
    .state     (curState)
  );

  assign state   = curState;
  assign ctrlOut = strobe.ctrl;
endmodule

// File: rtl/seqChecker.sv
module seqChecker
  import seqPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [COND_W-1:0] cond,
  input logic [CTRL_W-1:0] ctrlOut,
  input logic [STATE_W-1:0] state
);
  function automatic logic [COND_W-1:0] keepSelected(state_t s, logic [COND_W-1:0] c);
    logic [COND_W-1:0] m;
    m = 4'b0000;
    m[s[0] ? 1 : 0] = 1'b1;
    m[s[1] ? 3 : 2] = 1'b1;
    return c & m;
  endfunction

  function automatic state_t refNext(state_t s, logic [COND_W-1:0] c);
    logic a;
    logic b;
    a = s[0] ? c[1] : c[0];
    b = s[1] ? c[3] : c[2];
    return progNext(s, {b, a});
  endfunction

  a_r1_reset_to_zero: assert property (@(posedge clk) rst |=> state == '0);

  a_r2_ctrl_of_state: assert property (@(posedge clk) disable iff (rst)
    ctrlOut == progCtrl(state));

  a_r4_next_state: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> state == refNext($past(state), $past(cond)));

  a_r5_unselected_ignored: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> state == refNext($past(state), keepSelected($past(state), $past(cond))));
endmodule

bind seqBranchSequencer seqChecker u_seqChecker (
  .clk     (clk),
  .rst     (rst),
  .cond    (cond),
  .ctrlOut (ctrlOut),
  .state   (state)
);

// File: tb/tb_seqBranchSequencer.sv
module tb_seqBranchSequencer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] cond = 4'b0;
  logic [13:0] ctrlV, ctrlH;
  logic [3:0] stateV, stateH;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int expState = 0;

  always #5 clk = ~clk;

  seqBranchSequencer #(.IS_HORIZONTAL(1'b0)) dut (
    .clk(clk), .rst(rst), .cond(cond), .ctrlOut(ctrlV), .state(stateV));
  seqBranchSequencer #(.IS_HORIZONTAL(1'b1)) dutH (
    .clk(clk), .rst(rst), .cond(cond), .ctrlOut(ctrlH), .state(stateH));

  function automatic int expNext(int s, logic [3:0] c);
    int a;
    int b;
    a = (s % 2 == 1) ? int'(c[1]) : int'(c[0]);
    b = ((s / 2) % 2 == 1) ? int'(c[3]) : int'(c[2]);
    return (5 * s + 3 * (2 * b + a) + 1) % 16;
  endfunction

  function automatic logic [13:0] expCtrl(int s);
    logic [3:0] v;
    v = 4'(s);
    return {~v, v, v ^ 4'h5, v[3] ^ v[0], v[1]};
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: compare outputs with the model.
  task automatic checkOutputs(string reqState);
    check(reqState, int'(stateV), expState);
    check("R2", int'(ctrlV), int'(expCtrl(expState)));
    check("R6 state", int'(stateH), int'(stateV));
    check("R6 ctrl", int'(ctrlH), int'(ctrlV));
  endtask

  task automatic stepWith(logic [3:0] c, string reqState);
    cond = c;
    expState = expNext(expState, c);
    @(negedge clk);
    checkOutputs(reqState);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expState = 0;
    checkOutputs("R1");
    rst = 1'b0;
    // R3 directed: walk states with single-hot conditions
    for (int i = 0; i < 16; i++) stepWith(4'(1 << (i % 4)), "R3");
    for (int i = 0; i < 8; i++) stepWith(4'hF, "R4");
    for (int i = 0; i < 8; i++) stepWith(4'h0, "R4");
    // R5: selected bits random, unselected bits toggled against them
    for (int i = 0; i < 40; i++) begin
      logic [3:0] c;
      int s;
      int ia;
      int ib;
      s = expState;
      c = 4'($urandom);
      ia = (s % 2 == 1) ? 1 : 0;
      ib = ((s / 2) % 2 == 1) ? 3 : 2;
      c[1 - ia] = ~c[ia];
      c[5 - ib] = ~c[ib];
      stepWith(c, "R5");
    end
    // R7: change cond between edges, state must hold
    for (int i = 0; i < 10; i++) begin
      cond = 4'($urandom);
      #2;
      check("R7", int'(stateV), expState);
      cond = ~cond;
      #1;
      check("R7", int'(stateV), expState);
      stepWith(4'($urandom), "R4");
    end
    // Random run
    for (int i = 0; i < 400; i++) stepWith(4'($urandom), "R4");
    // Mid-run reset
    rst = 1'b1;
    cond = 4'($urandom);
    @(negedge clk);
    expState = 0;
    checkOutputs("R1");
    rst = 1'b0;
    for (int i = 0; i < 50; i++) stepWith(4'($urandom), "R4");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #2000000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule